// File: doc/BRIEF.md
# Unaligned Byte-to-Halfword Write Packer

This block turns a byte-granular write request into a series of 16-bit write commands for a memory that only accepts whole halfwords. A request gives a byte start address, a byte count and then a stream of source bytes. The block pairs bytes that line up with halfword boundaries and writes each pair as one little-endian halfword. A byte that sits alone in its halfword is handled by read-modify-write. That happens for an odd start address or a single byte left over at the end. The block reads the current halfword, replaces the one byte and writes the result back.

The block keeps exactly one write command in flight. It waits for the memory's done pulse before it fetches the next bytes. It pulls source bytes only when the next command needs them, so a slow memory holds back the byte source. When the last command has completed, the block pulses a request-done strobe and returns to idle.

Top module: `hw_write_packer`

## Requirements
- R1: Two bytes written as a pair go to an even halfword address: the first byte in bits 7:0 and the second byte in bits 15:8.
- R2: A lone byte at an odd address triggers a read of the halfword at that address with bit 0 cleared. The written value is {new byte, read bits 7:0}.
- R3: A lone trailing byte at an even address triggers a read of its halfword. The written value is {read bits 15:8, new byte}.
- R4: When the start address is odd, the first command is a lone-byte write to the halfword at the start address with bit 0 cleared. The remaining bytes then start on an even address.
- R5: Every halfword address presented on the write port and on the read port has bit 0 equal to 0. The total number of write commands is the number of lone bytes plus the number of pairs.
- R6: A request with count 0 issues no read, no write and takes no source byte. Its done pulse appears two cycles after acceptance.
- R7: A write command keeps wr_valid, wr_addr and wr_data unchanged until the cycle in which wr_done is sampled high. The next command is issued only after that.
- R8: req_done is a one-cycle pulse. It is raised only after the last command of the request has completed, and it is raised while the block is back in idle (req_ready high).
- R9: src_ready is low whenever a write command is pending or a read is issued. Exactly count source bytes are taken per request.
- R10: A read is issued only for lone-byte writes, never while a write command is pending. The read data is taken one cycle after rd_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted when valid |
| req_addr | input | ADDR_W | Byte start address |
| req_count | input | CNT_W | Number of bytes to write |
| req_done | output | 1 | One-cycle pulse after the last command completes |
| src_valid | input | 1 | Source byte available |
| src_ready | output | 1 | Block takes the source byte this cycle |
| src_byte | input | 8 | Source byte |
| rd_en | output | 1 | Halfword read strobe |
| rd_addr | output | ADDR_W | Halfword read address (bit 0 zero) |
| rd_data | input | 16 | Read data, valid the cycle after rd_en |
| wr_valid | output | 1 | Write command pending |
| wr_addr | output | ADDR_W | Halfword write address (bit 0 zero) |
| wr_data | output | 16 | Halfword write data |
| wr_done | input | 1 | Memory finished the pending write |

## Verification
The assertions assume that the memory raises wr_done only while a command is pending, and for only one cycle per command. They also assume that read data comes back exactly one cycle after the strobe, and that the byte-end address of a request does not wrap. The bench's memory model responds with a variable delay but stays inside this contract. Its source withholds bytes on a periodic pattern to exercise the stall paths. Every request it issues fits inside its small address space, and it keeps req_valid raised for a single cycle while the block is idle.

// File: rtl/hwp_pkg.sv
package hwp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_PLAN     = 3'd1,
        ST_FETCH_LO = 3'd2,
        ST_FETCH_HI = 3'd3,
        ST_READ     = 3'd4,
        ST_MERGE    = 3'd5,
        ST_WRITE    = 3'd6
    } hwp_state_e;

    typedef enum logic [1:0] {
        OP_NONE   = 2'd0,
        OP_SINGLE = 2'd1,
        OP_PAIR   = 2'd2
    } hwp_op_e;

endpackage

// File: rtl/hwp_plan.sv
module hwp_plan
    import hwp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             addr_odd,
    input  logic [CNT_W-1:0] remaining,
    output hwp_op_e          op
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    always_comb begin
        if (remaining == '0) begin
            op = OP_NONE;
        end else if (addr_odd || remaining == ONE) begin
            op = OP_SINGLE;
        end else begin
            op = OP_PAIR;
        end
    end

endmodule

// File: rtl/hwp_merge.sv
module hwp_merge (
    input  logic        hi_lane,
    input  logic [7:0]  new_byte,
    input  logic [15:0] old_half,
    output logic [15:0] merged
);

    always_comb begin
        if (hi_lane) begin
            merged = {new_byte, old_half[7:0]};
        end else begin
            merged = {old_half[15:8], new_byte};
        end
    end

endmodule

// File: rtl/hw_write_packer.sv
module hw_write_packer
    import hwp_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CNT_W-1:0]  req_count,
    output logic              req_done,
    input  logic              src_valid,
    output logic              src_ready,
    input  logic [7:0]        src_byte,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [15:0]       rd_data,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [15:0]       wr_data,
    input  logic              wr_done
);

    localparam logic [ADDR_W-1:0] A_ONE = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_TWO = ADDR_W'(2);
    localparam logic [CNT_W-1:0]  C_ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0]  C_TWO = CNT_W'(2);

    typedef struct packed {
        hwp_state_e        st;
        hwp_op_e           op;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  cnt;
        logic [7:0]        lo;
        logic [15:0]       wdata;
        logic              done;
    } regs_t;

    regs_t   cur_q;
    regs_t   nxt_d;
    hwp_op_e plan_op;
    logic [15:0] merged;
    logic [ADDR_W-1:0] addr_step;
    logic [CNT_W-1:0]  cnt_step;

    hwp_plan #(.CNT_W(CNT_W)) u_plan (
        .addr_odd  (cur_q.addr[0]),
        .remaining (cur_q.cnt),
        .op        (plan_op)
    );

    hwp_merge u_merge (
        .hi_lane  (cur_q.addr[0]),
        .new_byte (cur_q.lo),
        .old_half (rd_data),
        .merged   (merged)
    );

    always_comb begin
        addr_step = (cur_q.op == OP_PAIR) ? A_TWO : A_ONE;
        cnt_step  = (cur_q.op == OP_PAIR) ? C_TWO : C_ONE;
    end

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.done = 1'b0;
        src_ready  = 1'b0;
        rd_en      = 1'b0;
        wr_valid   = 1'b0;
        case (cur_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    nxt_d.addr = req_addr;
                    nxt_d.cnt  = req_count;
                    nxt_d.st   = ST_PLAN;
                end
            end
            ST_PLAN: begin
                nxt_d.op = plan_op;
                if (plan_op == OP_NONE) begin
                    nxt_d.done = 1'b1;
                    nxt_d.st   = ST_IDLE;
                end else begin
                    nxt_d.st = ST_FETCH_LO;
                end
            end
            ST_FETCH_LO: begin
                src_ready = 1'b1;
                if (src_valid) begin
                    nxt_d.lo = src_byte;
                    nxt_d.st = (cur_q.op == OP_PAIR) ? ST_FETCH_HI : ST_READ;
                end
            end
            ST_FETCH_HI: begin
                src_ready = 1'b1;
                if (src_valid) begin
                    nxt_d.wdata = {src_byte, cur_q.lo};
                    nxt_d.st    = ST_WRITE;
                end
            end
            ST_READ: begin
                rd_en    = 1'b1;
                nxt_d.st = ST_MERGE;
            end
            ST_MERGE: begin
                nxt_d.wdata = merged;
                nxt_d.st    = ST_WRITE;
            end
            ST_WRITE: begin
                wr_valid = 1'b1;
                if (wr_done) begin
                    nxt_d.addr = cur_q.addr + addr_step;
                    nxt_d.cnt  = cur_q.cnt - cnt_step;
                    nxt_d.st   = ST_PLAN;
                end
            end
            default: begin
                nxt_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    always_comb begin
        req_ready = (cur_q.st == ST_IDLE);
        req_done  = cur_q.done;
        rd_addr   = {cur_q.addr[ADDR_W-1:1], 1'b0};
        wr_addr   = {cur_q.addr[ADDR_W-1:1], 1'b0};
        wr_data   = cur_q.wdata;
    end

endmodule

// File: rtl/hwp_checker.sv
module hwp_checker #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [CNT_W-1:0]  req_count,
    input logic              req_done,
    input logic              src_ready,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              wr_valid,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [15:0]       wr_data,
    input logic              wr_done
);

    // R7
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !wr_done |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

    // R5
    wr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> !wr_addr[0]);

    // R10
    rd_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> !rd_addr[0] && !wr_valid);

    // R9
    src_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        src_ready |-> !wr_valid && !rd_en);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_done |=> !req_done);

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_done |-> req_ready && !wr_valid);

    // R6
    zero_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && req_count == '0 |-> ##2 req_done);

    // R6
    zero_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && req_count == '0 |=> !src_ready && !rd_en && !wr_valid);

endmodule

bind hw_write_packer hwp_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_count (req_count),
    .req_done  (req_done),
    .src_ready (src_ready),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .wr_valid  (wr_valid),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .wr_done   (wr_done)
);

// File: tb/hw_write_packer_test.sv
module hw_write_packer_test;

    localparam int AW    = 6;
    localparam int CW    = 16;
    localparam int MSIZE = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [CW-1:0] req_count = '0;
    logic          req_done;
    logic          src_valid = 1'b0;
    logic          src_ready;
    logic [7:0]    src_byte;
    logic          rd_en;
    logic [AW-1:0] rd_addr;
    logic [15:0]   rd_data = '0;
    logic          wr_valid;
    logic [AW-1:0] wr_addr;
    logic [15:0]   wr_data;
    logic          wr_done = 1'b0;

    logic [7:0] mem [MSIZE];
    logic [7:0] refm [MSIZE];
    int checks = 0;
    int fails = 0;
    int src_idx = 0;
    int wr_cnt = 0;
    int rd_cnt = 0;
    int done_cnt = 0;
    int first_wa = -1;
    int wait_c = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    hw_write_packer #(.ADDR_W(AW), .CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_count(req_count), .req_done(req_done),
        .src_valid(src_valid), .src_ready(src_ready), .src_byte(src_byte),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_done(wr_done)
    );

    function automatic logic [7:0] byte_of(int i);
        return 8'((i * 29 + 7) & 255);
    endfunction

    assign src_byte = byte_of(src_idx);

    always @(negedge clk) begin
        cyc <= cyc + 1;
        src_valid <= (cyc % 5) != 3;
    end

    // memory and source models
    always @(posedge clk) begin
        if (src_valid && src_ready) src_idx <= src_idx + 1;
        if (req_done) done_cnt <= done_cnt + 1;
        if (rd_en) begin
            rd_data <= {mem[int'(rd_addr) + 1], mem[int'(rd_addr)]};
            rd_cnt  <= rd_cnt + 1;
        end
        wr_done <= 1'b0;
        if (wr_valid && !wr_done) begin
            if (wait_c == (int'(wr_addr) >> 1) % 3) begin
                mem[int'(wr_addr)]     <= wr_data[7:0];
                mem[int'(wr_addr) + 1] <= wr_data[15:8];
                if (first_wa < 0) first_wa <= int'(wr_addr);
                wr_cnt  <= wr_cnt + 1;
                wr_done <= 1'b1;
                wait_c  <= 0;
            end else begin
                wait_c <= wait_c + 1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run_req(input int a, input int n);
        int s0, w0, r0, d0, ew, er, ra, rn, bad;
        s0 = src_idx; w0 = wr_cnt; r0 = rd_cnt; d0 = done_cnt;
        ew = 0; er = 0; ra = a; rn = n;
        while (rn > 0) begin
            if ((ra % 2) == 1 || rn == 1) begin
                er++; ew++; ra += 1; rn -= 1;
            end else begin
                ew++; ra += 2; rn -= 2;
            end
        end
        for (int i = 0; i < n; i++) refm[a + i] = byte_of(s0 + i);
        @(negedge clk);
        first_wa  = -1;
        req_valid = 1'b1;
        req_addr  = AW'(a);
        req_count = CW'(n);
        @(negedge clk);
        req_valid = 1'b0;
        while (done_cnt == d0) @(negedge clk);
        repeat (2) @(negedge clk);
        bad = 0;
        for (int i = 0; i < MSIZE; i++) if (mem[i] !== refm[i]) bad++;
        // R1 R2 R3: memory image matches little-endian byte placement and merge
        check(bad == 0, "R1/R2/R3 memory image mismatching bytes", bad, 0);
        // R5 number of commands
        check(wr_cnt - w0 == ew, "R5 write command count", wr_cnt - w0, ew);
        // R10 reads only for lone bytes
        check(rd_cnt - r0 == er, "R10 read count", rd_cnt - r0, er);
        // R9 bytes consumed
        check(src_idx - s0 == n, "R9 source bytes taken", src_idx - s0, n);
        // R8 single done pulse
        check(done_cnt - d0 == 1, "R8 done pulses", done_cnt - d0, 1);
        if (n == 0) begin
            // R6 zero count
            check(wr_cnt == w0 && rd_cnt == r0, "R6 zero-count activity", wr_cnt - w0 + rd_cnt - r0, 0);
        end else if ((a % 2) == 1) begin
            // R4 first write at start address with bit 0 cleared
            check(first_wa == a - 1, "R4 first write address", first_wa, a - 1);
        end
    endtask

    initial begin
        for (int i = 0; i < MSIZE; i++) begin
            mem[i]  = 8'(i) ^ 8'hA5;
            refm[i] = 8'(i) ^ 8'hA5;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1, "R8 reset req_ready", int'(req_ready), 1);
        check(wr_valid == 1'b0, "R7 reset wr_valid", int'(wr_valid), 0);
        check(src_ready == 1'b0, "R9 reset src_ready", int'(src_ready), 0);
        check(rd_en == 1'b0, "R10 reset rd_en", int'(rd_en), 0);
        check(req_done == 1'b0, "R8 reset req_done", int'(req_done), 0);
        for (int s = 0; s < 8; s++) begin
            for (int n = 0; n < 8; n++) begin
                run_req(8 + s, n);
            end
        end
        run_req(33, 30);
        run_req(20, 44);
        run_req(0, 1);
        run_req(63, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule